// File: doc/BRIEF.md
# Set-Conditional and Compare-Branch Unit

This unit supplies every conditional decision for a pipeline that keeps no condition flags. Each instruction it accepts carries two operands and a 4-bit relation selector, and is one of two kinds. A set-conditional instruction produces a full-word boolean: every bit is one when the relation holds and every bit is zero when it does not. That mask can then be combined with other booleans by an ordinary logical ALU operation. A compare-and-jump instruction produces a taken/not-taken decision together with a PC-relative target.

The work is split across two pipeline stages. In the operand-decode cycle the unit captures the operands and the relation, and computes the branch target as the delay-slot PC plus a sign-extended word offset. In the following execute cycle it evaluates the relation. Results leave through registers, so they are visible after the second rising clock edge counted from the strobe. A small enumerated stage machine records what occupies the execute stage: `ST_IDLE` when it is empty, `ST_SETC` for a set-conditional and `ST_JUMP` for a compare-and-jump. On every edge the machine moves to `ST_SETC` on a strobe with `in_kind` = 0, to `ST_JUMP` on a strobe with `in_kind` = 1, and to `ST_IDLE` when there is no strobe. There is no stall. The instruction after a branch, which is its delay slot, is accepted in the very next cycle and always yields its own result.

Top module: `setcmp_unit`

## Requirements
- R1: While `rst_n` is low, and until the first strobe has passed through, `res_valid`, `res_mask`, `jmp_valid`, `jmp_taken` and `jmp_target` are all zero.
- R2: A set-conditional strobe sampled at clock edge N makes `res_valid` high for exactly the cycle after edge N+1. In that cycle `res_mask` is all ones when the relation holds and all zeros when it does not.
- R3: The relation codes are as follows. 0 is never and 1 is always. 2 is a==b and 3 is a!=b. 12 means a is zero or negative, 13 means a is positive, 14 means a is negative and 15 means a is zero or positive. The codes 12 to 15 look only at `in_a`.
- R4: Codes 4 to 7 compare a and b as two's-complement values: 4 is a<b, 5 is a<=b, 6 is a>b and 7 is a>=b. Codes 8 to 11 make the same four comparisons as unsigned values.
- R5: A compare-and-jump strobe sampled at edge N makes `jmp_valid` high for exactly the cycle after edge N+1. In that cycle `jmp_taken` equals the relation result and `res_valid` stays low.
- R6: In the cycle that `jmp_valid` is high, `jmp_target` equals `in_pc` + 1 + sign-extended `in_off`, taken from the strobed instruction and computed modulo 2^32.
- R7: Each compare-and-jump gives exactly one `jmp_valid` pulse, and `jmp_taken` is never high without it. A strobe is accepted in every cycle, including the cycle right after a branch, and each accepted instruction gives its own result with no stall.
- R8: A cycle with no strobe gives a following output cycle in which both valid flags are low and `jmp_taken`, `res_mask` and `jmp_target` are zero.
- R9: `in_kind` selects the form of the instruction: 0 is set-conditional and 1 is compare-and-jump. The two valid outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe for this cycle |
| in_kind | input | 1 | 0 set-conditional, 1 compare-and-jump |
| in_cond | input | 4 | Relation selector |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_pc | input | 32 | Word address of the instruction |
| in_off | input | 16 | Signed word offset for the branch |
| res_valid | output | 1 | Set-conditional result present |
| res_mask | output | 32 | All-ones or all-zeros boolean |
| jmp_valid | output | 1 | Compare-and-jump decision present |
| jmp_taken | output | 1 | Branch is taken |
| jmp_target | output | 32 | Branch target word address |

## Verification
The assertions rely on `in_kind`, `in_cond` and the operands being known whenever `in_valid` is high. They also rely on `rst_n` being held for at least two edges before the first strobe. The bench meets both conditions. It drives every input from a task on the falling edge, keeps `in_valid` low for the whole reset period, and gives defined values to every field of every instruction, including those of idle cycles. The stimulus then walks all sixteen relation codes over operand pairs that separate the signed and unsigned orderings, runs uninterrupted branch and set sequences back to back, and uses offsets and PCs at their wrap limits.

// File: rtl/setcmp_pkg.sv
package setcmp_pkg;

    typedef enum logic [3:0] {
        REL_NEVER  = 4'd0,
        REL_ALWAYS = 4'd1,
        REL_EQ     = 4'd2,
        REL_NE     = 4'd3,
        REL_LT     = 4'd4,
        REL_LE     = 4'd5,
        REL_GT     = 4'd6,
        REL_GE     = 4'd7,
        REL_LTU    = 4'd8,
        REL_LEU    = 4'd9,
        REL_GTU    = 4'd10,
        REL_GEU    = 4'd11,
        REL_LEZ    = 4'd12,
        REL_GTZ    = 4'd13,
        REL_LTZ    = 4'd14,
        REL_GEZ    = 4'd15
    } rel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SETC = 2'd1,
        ST_JUMP = 2'd2
    } stage_e;

endpackage

// File: rtl/setcmp_target.sv
module setcmp_target #(
    parameter int WIDTH = 32,
    parameter int OFF_W = 16
) (
    input  logic [WIDTH-1:0] pc,
    input  logic [OFF_W-1:0] off,
    output logic [WIDTH-1:0] target
);
    logic [WIDTH-1:0] off_ext;

    generate
        if (OFF_W >= WIDTH) begin : g_trunc
            assign off_ext = off[WIDTH-1:0];
        end else begin : g_sext
            assign off_ext = {{(WIDTH-OFF_W){off[OFF_W-1]}}, off};
        end
    endgenerate

    // Delay-slot PC plus the sign-extended word offset.
    assign target = pc + WIDTH'(1) + off_ext;
endmodule

// File: rtl/setcmp_eval.sv
module setcmp_eval
    import setcmp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  rel_e             cond,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             holds
);
    logic eq, lt_s, lt_u, a_zero, a_neg;

    always_comb begin
        eq     = (a == b);
        lt_u   = (a < b);
        lt_s   = ($signed(a) < $signed(b));
        a_zero = (a == '0);
        a_neg  = a[WIDTH-1];
    end

    always_comb begin
        holds = 1'b0;
        unique case (cond)
            REL_NEVER:  holds = 1'b0;
            REL_ALWAYS: holds = 1'b1;
            REL_EQ:     holds = eq;
            REL_NE:     holds = !eq;
            REL_LT:     holds = lt_s;
            REL_LE:     holds = lt_s || eq;
            REL_GT:     holds = !lt_s && !eq;
            REL_GE:     holds = !lt_s;
            REL_LTU:    holds = lt_u;
            REL_LEU:    holds = lt_u || eq;
            REL_GTU:    holds = !lt_u && !eq;
            REL_GEU:    holds = !lt_u;
            REL_LEZ:    holds = a_neg || a_zero;
            REL_GTZ:    holds = !a_neg && !a_zero;
            REL_LTZ:    holds = a_neg;
            REL_GEZ:    holds = !a_neg;
            default:    holds = 1'b0;
        endcase
    end
endmodule

// File: rtl/setcmp_unit.sv
module setcmp_unit
    import setcmp_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_kind,
    input  logic [3:0]       in_cond,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [WIDTH-1:0] in_pc,
    input  logic [OFF_W-1:0] in_off,
    output logic             res_valid,
    output logic [WIDTH-1:0] res_mask,
    output logic             jmp_valid,
    output logic             jmp_taken,
    output logic [WIDTH-1:0] jmp_target
);
    stage_e           state_q, state_d;
    rel_e             cond_q;
    logic [WIDTH-1:0] a_q, b_q, tgt_q, tgt_d;
    logic             holds;

    // Operand-decode stage: target formed here.
    setcmp_target #(.WIDTH(WIDTH), .OFF_W(OFF_W)) u_tgt (
        .pc(in_pc), .off(in_off), .target(tgt_d)
    );

    // Execute stage: relation evaluated on captured operands.
    setcmp_eval #(.WIDTH(WIDTH)) u_eval (
        .cond(cond_q), .a(a_q), .b(b_q), .holds(holds)
    );

    always_comb begin
        state_d = ST_IDLE;
        if (in_valid) state_d = in_kind ? ST_JUMP : ST_SETC;
    end

    // State register and stage operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cond_q  <= REL_NEVER;
            a_q     <= '0;
            b_q     <= '0;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) begin
                cond_q <= rel_e'(in_cond);
                a_q    <= in_a;
                b_q    <= in_b;
                tgt_q  <= tgt_d;
            end
        end
    end

    // Output registers driven from the execute-stage state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_mask   <= '0;
            jmp_valid  <= 1'b0;
            jmp_taken  <= 1'b0;
            jmp_target <= '0;
        end else begin
            res_valid  <= 1'b0;
            res_mask   <= '0;
            jmp_valid  <= 1'b0;
            jmp_taken  <= 1'b0;
            jmp_target <= '0;
            unique case (state_q)
                ST_IDLE: ;
                ST_SETC: begin
                    res_valid <= 1'b1;
                    res_mask  <= {WIDTH{holds}};
                end
                ST_JUMP: begin
                    jmp_valid  <= 1'b1;
                    jmp_taken  <= holds;
                    jmp_target <= tgt_q;
                end
                default: ;
            endcase
        end
    end

    // R2: a set result is a uniform mask
    p_mask_uniform_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_mask == '0 || res_mask == '1));

    // R8: idle output cycles carry zeros
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_mask == '0));

    // R9: the two forms never report together
    p_one_form_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && jmp_valid));

    // R7: taken only alongside a decision
    p_taken_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_taken |-> jmp_valid);

    // R5: a branch in execute reports on the next edge
    p_jump_reports_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUMP) |=> (jmp_valid && !res_valid));

    // R3: never and always are fixed outcomes
    p_never_always_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUMP && (cond_q == REL_NEVER || cond_q == REL_ALWAYS))
        |=> (jmp_taken == $past(cond_q == REL_ALWAYS)));

    // R6: target follows the strobed pc and offset
    p_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_valid |-> (jmp_target == $past(in_pc, 2) + WIDTH'(1)
                       + WIDTH'($signed($past(in_off, 2)))));
endmodule

// File: tb/sim_setcmp_unit.sv
module sim_setcmp_unit;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_kind;
    logic [3:0]  in_cond;
    logic [31:0] in_a, in_b, in_pc;
    logic [15:0] in_off;
    logic        res_valid, jmp_valid, jmp_taken;
    logic [31:0] res_mask, jmp_target;

    int vectors = 0;
    int errors  = 0;

    bit          q_rv[$];
    bit          q_jv[$];
    bit          q_jt[$];
    logic [31:0] q_rm[$];
    logic [31:0] q_tg[$];
    string       q_tag[$];

    always #(PERIOD/2) clk = ~clk;

    setcmp_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_cond(in_cond), .in_a(in_a), .in_b(in_b), .in_pc(in_pc),
        .in_off(in_off), .res_valid(res_valid), .res_mask(res_mask),
        .jmp_valid(jmp_valid), .jmp_taken(jmp_taken), .jmp_target(jmp_target)
    );

    function automatic bit ref_rel(int c, logic [31:0] a, logic [31:0] b);
        case (c)
            0:  return 1'b0;
            1:  return 1'b1;
            2:  return a == b;
            3:  return a != b;
            4:  return $signed(a) <  $signed(b);
            5:  return $signed(a) <= $signed(b);
            6:  return $signed(a) >  $signed(b);
            7:  return $signed(a) >= $signed(b);
            8:  return a <  b;
            9:  return a <= b;
            10: return a >  b;
            11: return a >= b;
            12: return $signed(a) <= 0;
            13: return $signed(a) >  0;
            14: return $signed(a) <  0;
            default: return $signed(a) >= 0;
        endcase
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    task automatic push_exp(bit rv, logic [31:0] rm, bit jv, bit jt,
                            logic [31:0] tg, string tag);
        q_rv.push_back(rv); q_rm.push_back(rm); q_jv.push_back(jv);
        q_jt.push_back(jt); q_tg.push_back(tg); q_tag.push_back(tag);
    endtask

    task automatic step(bit v, bit k, int c, logic [31:0] a, logic [31:0] b,
                        logic [31:0] pc, logic [15:0] off);
        bit          e_rv, e_jv, e_jt;
        logic [31:0] e_rm, e_tg;
        string       tag;
        bit          r;
        @(negedge clk);
        e_rv = q_rv.pop_front(); e_rm = q_rm.pop_front();
        e_jv = q_jv.pop_front(); e_jt = q_jt.pop_front();
        e_tg = q_tg.pop_front(); tag  = q_tag.pop_front();
        vectors++;
        if (res_valid !== e_rv || res_mask !== e_rm || jmp_valid !== e_jv ||
            jmp_taken !== e_jt || jmp_target !== e_tg) begin
            errors++;
            $display("FAIL %s: got rv=%0b rm=%h jv=%0b jt=%0b tg=%h exp rv=%0b rm=%h jv=%0b jt=%0b tg=%h",
                     tag, res_valid, res_mask, jmp_valid, jmp_taken, jmp_target,
                     e_rv, e_rm, e_jv, e_jt, e_tg);
        end
        in_valid = v; in_kind = k; in_cond = 4'(c);
        in_a = a; in_b = b; in_pc = pc; in_off = off;
        r = ref_rel(c, a, b);
        if (!v)
            push_exp(0, '0, 0, 0, '0, "R8");
        else if (!k)
            push_exp(1, r ? 32'hFFFF_FFFF : 32'h0, 0, 0, '0,
                     (c >= 4 && c <= 11) ? "R2 R4 R9" : "R2 R3 R9");
        else
            push_exp(0, '0, 1, r, pc + 32'd1 + {{16{off[15]}}, off},
                     (c >= 4 && c <= 11) ? "R5 R6 R7 R4" : "R5 R6 R7 R3");
    endtask

    function automatic logic [31:0] opa(int p);
        case (p)
            0: return 32'd5;
            1: return 32'd3;
            2: return 32'd7;
            3: return 32'hFFFF_FFFF;
            4: return 32'd0;
            default: return 32'h8000_0000;
        endcase
    endfunction

    function automatic logic [31:0] opb(int p);
        case (p)
            0: return 32'd5;
            1: return 32'd7;
            2: return 32'd3;
            3: return 32'd1;
            4: return 32'h8000_0000;
            default: return 32'h7FFF_FFFF;
        endcase
    endfunction

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 0; in_kind = 0; in_cond = 0;
        in_a = 0; in_b = 0; in_pc = 0; in_off = 0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        vectors++;
        if (res_valid !== 0 || res_mask !== 0 || jmp_valid !== 0 ||
            jmp_taken !== 0 || jmp_target !== 0) begin
            errors++;
            $display("FAIL R1: got rv=%0b rm=%h jv=%0b jt=%0b tg=%h exp all zero",
                     res_valid, res_mask, jmp_valid, jmp_taken, jmp_target);
        end
        push_exp(0, '0, 0, 0, '0, "R1");
        push_exp(0, '0, 0, 0, '0, "R1");
        rst_n = 1'b1;

        // R3 R4: every code as set-conditional over distinguishing pairs
        for (int c = 0; c < 16; c++)
            for (int p = 0; p < 6; p++)
                step(1, 0, c, opa(p), opb(p), 32'd0, 16'd0);

        // R5 R6: every code as compare-and-jump, offsets at limits
        for (int c = 0; c < 16; c++)
            for (int p = 0; p < 6; p++)
                step(1, 1, c, opa(p), opb(p), 32'h1000 * p + 32'(c),
                     (p % 3 == 0) ? 16'h8000 : (p % 3 == 1) ? 16'h7FFF : 16'hFFFF);

        // R6: pc wrap
        step(1, 1, 1, 0, 0, 32'hFFFF_FFFF, 16'd4);
        step(1, 1, 1, 0, 0, 32'h0000_0002, 16'hFFFD);

        // R7: branch with delay slot immediately following, then gaps (R8)
        for (int i = 0; i < 20; i++) begin
            step(1, 1, 2, 32'(i), 32'(i % 3), 32'(i * 4), 16'(i));
            step(1, 0, 3, 32'(i), 32'(i % 2), 32'd0, 16'd0);
            if (i % 4 == 0) step(0, 1, 1, 32'd9, 32'd9, 32'd77, 16'd5);
        end

        // R9: mixed random traffic
        for (int i = 0; i < 400; i++)
            step(($urandom % 4) != 0, $urandom % 2, $urandom % 16,
                 ($urandom % 3 == 0) ? 32'($urandom % 4) : $urandom,
                 ($urandom % 3 == 0) ? 32'($urandom % 4) : $urandom,
                 $urandom, 16'($urandom));

        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        summary();
        $finish;
    end
endmodule